// File: doc/BRIEF.md
# Multithreaded Commit Thread Selector

This block decides, every cycle, which hardware thread gets the next retirement slot of a shared commit stage. Each thread reports a commit status code, whether the oldest entry of its reorder buffer is ready, whether that buffer is empty, the sequence number of that oldest entry, and whether the thread is active. A policy input picks the selection rule. Two rules are available: a rotating-priority rule that keeps an ordered list of threads, and an oldest-first rule that compares sequence numbers. The result is a thread index with a valid flag. Both are computed combinationally from the current inputs.

The grant is offered as a valid/ready pair. `grant_valid` and `grant_tid` depend only on the current inputs and never wait for `grant_ready`. The offer counts as consumed on a rising clock edge where both `grant_valid` and `grant_ready` are high. Consumption affects only the rotating list, and only when the rotating rule is selected. A separate deactivate request removes a thread from the rotating list for good, until the next reset. A build with a single thread collapses to a simple status gate.

Top module: `commit_thread_sel`

## Requirements
- R1: Only statuses idle (code 0), running (code 1) and fetch-trap-pending (code 4) allow a grant. Codes 2 (squashing), 3 (trap pending), 5 (squash-after pending), 6 and 7 never allow a grant. Thread i's status sits in `thr_status[3*i+2:3*i]`.
- R2: With more than one thread, a thread qualifies only when its `head_rdy` bit is 1 and its `rob_empty` bit is 0.
- R3: Under policy code 0 (rotating), the grant goes to the first qualifying thread in the rotating list, scanned from the front. After reset the list is thread 0, 1, ..., N-1.
- R4: When a rotating grant is consumed, the granted thread moves to the back of the list on that edge, and the other threads keep their relative order. If `grant_ready` is low, the list is unchanged.
- R5: Under policy code 1 (oldest-first), the grant goes to the qualifying thread with `active` set that has the smallest `head_seq`. Thread i's sequence number sits in bits `[SEQ_W*i +: SEQ_W]`. On equal sequence numbers, the lowest thread index wins.
- R6: Policy code 2 (greedy) and code 3 select exactly as code 1 does.
- R7: When no thread qualifies, `grant_valid` is 0 and `grant_tid` is 0.
- R8: A deactivate request (`deact_valid` with `deact_tid`) removes that thread from the rotating list on the next edge, and the thread is never again granted under policy 0. A request for a thread that is not in the list has no effect. When a removal and a consumed rotating grant fall in the same cycle, the removal is applied and the rotation is dropped.
- R9: Grants consumed under policies 1 to 3 leave the rotating list unchanged.
- R10: The grant reflects input changes in the same cycle, with no register on the path.
- R11: With NTHREADS = 1, `grant_valid` is high exactly when `active[0]` is set and the status allows a grant (R1). Readiness and emptiness are ignored in this build, and `grant_tid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | Selection rule: 0 rotating, 1 oldest-first, 2 greedy, 3 same as 1 |
| thr_status | input | 3*NTHREADS | Per-thread commit status codes |
| head_rdy | input | NTHREADS | Oldest buffer entry ready to retire |
| rob_empty | input | NTHREADS | Thread's reorder buffer holds nothing |
| head_seq | input | SEQ_W*NTHREADS | Sequence number of each thread's oldest entry |
| active | input | NTHREADS | Thread is active (used by oldest-first and single-thread builds) |
| deact_valid | input | 1 | Remove `deact_tid` from the rotating list |
| deact_tid | input | TID_W | Thread to remove |
| grant_ready | input | 1 | Consumer takes the offered grant this cycle |
| grant_valid | output | 1 | A thread is selected |
| grant_tid | output | TID_W | Selected thread, 0 when not valid |

## Verification
The bound checker watches four things on every cycle:
- every grant goes to a thread whose status and readiness allow it;
- an invalid grant always carries index 0;
- an oldest-first grant never skips an older qualifying active thread;
- a rotating grant never reaches a thread that was deactivated earlier.

The single-thread build is also checked against its gate equation on every cycle.

Some properties depend on history held in the rotating list, and only the bench's ordered scenarios can show them:
- the exact rotation order after a run of consumed grants;
- that the list stays unchanged without `grant_ready` or under the other policies;
- that a removal wins over a rotation in the same cycle.

// File: rtl/cts_pkg.sv
package cts_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RUN     = 3'd1,
    ST_SQUASH  = 3'd2,
    ST_TRAP    = 3'd3,
    ST_FTRAP   = 3'd4,
    ST_SQAFTER = 3'd5
  } cstat_e;

  typedef enum logic [1:0] {
    POL_ROTATE = 2'd0,
    POL_OLDEST = 2'd1,
    POL_GREEDY = 2'd2,
    POL_RSVD   = 2'd3
  } cpol_e;

  localparam int unsigned STAT_W = 3;

  // A thread may retire only in these three states.
  function automatic logic may_commit(input logic [STAT_W-1:0] s);
    return (s == ST_IDLE) || (s == ST_RUN) || (s == ST_FTRAP);
  endfunction

endpackage

// File: rtl/cts_age_pick.sv
module cts_age_pick #(
  parameter int NTHREADS = 4,
  parameter int SEQ_W    = 16,
  parameter int TID_W    = 2
) (
  input  logic [NTHREADS-1:0]       cand,
  input  logic [SEQ_W*NTHREADS-1:0] seq,
  output logic                      pick_valid,
  output logic [TID_W-1:0]          pick_tid
);

  logic [SEQ_W-1:0] best;

  // Ascending scan that replaces only on a strictly smaller value,
  // so the lowest index wins a tie.
  always_comb begin
    pick_valid = 1'b0;
    pick_tid   = '0;
    best       = '0;
    for (int i = 0; i < NTHREADS; i++) begin
      if (cand[i] && (!pick_valid || (seq[i*SEQ_W +: SEQ_W] < best))) begin
        pick_valid = 1'b1;
        pick_tid   = TID_W'(i);
        best       = seq[i*SEQ_W +: SEQ_W];
      end
    end
  end

endmodule

// File: rtl/cts_rr_order.sv
module cts_rr_order #(
  parameter int NTHREADS = 4,
  parameter int TID_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NTHREADS-1:0] qual,
  input  logic                take,
  input  logic                deact_valid,
  input  logic [TID_W-1:0]    deact_tid,
  output logic                pick_valid,
  output logic [TID_W-1:0]    pick_tid
);

  localparam int CNT_W = $clog2(NTHREADS + 1);

  logic [TID_W-1:0] order_q [NTHREADS];
  logic [TID_W-1:0] order_d [NTHREADS];
  logic [CNT_W-1:0] len_q, len_d;
  logic [TID_W-1:0] pick_pos;
  logic             d_found;
  logic [TID_W-1:0] d_pos;

  // Front-most qualifying entry: a descending scan leaves the lowest position.
  always_comb begin
    pick_valid = 1'b0;
    pick_tid   = '0;
    pick_pos   = '0;
    for (int i = NTHREADS - 1; i >= 0; i--) begin
      if ((CNT_W'(i) < len_q) && qual[order_q[i]]) begin
        pick_valid = 1'b1;
        pick_tid   = order_q[i];
        pick_pos   = TID_W'(i);
      end
    end
  end

  // Position of the thread named by a deactivate request, if it is listed.
  always_comb begin
    d_found = 1'b0;
    d_pos   = '0;
    for (int i = NTHREADS - 1; i >= 0; i--) begin
      if ((CNT_W'(i) < len_q) && (order_q[i] == deact_tid)) begin
        d_found = 1'b1;
        d_pos   = TID_W'(i);
      end
    end
  end

  // Removal wins over rotation in the same cycle.
  always_comb begin
    for (int i = 0; i < NTHREADS; i++) order_d[i] = order_q[i];
    len_d = len_q;
    if (deact_valid && d_found) begin
      for (int i = 0; i < NTHREADS - 1; i++)
        if (TID_W'(i) >= d_pos) order_d[i] = order_q[i+1];
      len_d = len_q - 1'b1;
    end else if (take && pick_valid) begin
      for (int i = 0; i < NTHREADS - 1; i++)
        if (TID_W'(i) >= pick_pos) order_d[i] = order_q[i+1];
      order_d[len_q - 1'b1] = pick_tid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTHREADS; i++) order_q[i] <= TID_W'(i);
      len_q <= CNT_W'(NTHREADS);
    end else begin
      for (int i = 0; i < NTHREADS; i++) order_q[i] <= order_d[i];
      len_q <= len_d;
    end
  end

endmodule

// File: rtl/commit_thread_sel.sv
module commit_thread_sel
  import cts_pkg::*;
#(
  parameter  int NTHREADS = 4,
  parameter  int SEQ_W    = 16,
  localparam int TID_W    = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  policy,
  input  logic [STAT_W*NTHREADS-1:0]  thr_status,
  input  logic [NTHREADS-1:0]         head_rdy,
  input  logic [NTHREADS-1:0]         rob_empty,
  input  logic [SEQ_W*NTHREADS-1:0]   head_seq,
  input  logic [NTHREADS-1:0]         active,
  input  logic                        deact_valid,
  input  logic [TID_W-1:0]            deact_tid,
  input  logic                        grant_ready,
  output logic                        grant_valid,
  output logic [TID_W-1:0]            grant_tid
);

  logic [NTHREADS-1:0] elig;

  always_comb begin
    for (int i = 0; i < NTHREADS; i++)
      elig[i] = may_commit(thr_status[i*STAT_W +: STAT_W]);
  end

  generate
    if (NTHREADS == 1) begin : g_single
      assign grant_valid = active[0] & elig[0];
      assign grant_tid   = '0;
    end else begin : g_multi
      logic [NTHREADS-1:0] head_ok;
      logic                rr_valid, age_valid;
      logic [TID_W-1:0]    rr_tid, age_tid;
      logic                use_rr;

      assign head_ok = head_rdy & ~rob_empty;
      assign use_rr  = (policy == POL_ROTATE);

      cts_rr_order #(.NTHREADS(NTHREADS), .TID_W(TID_W)) u_rr (
        .clk         (clk),
        .rst_n       (rst_n),
        .qual        (elig & head_ok),
        .take        (use_rr & grant_ready),
        .deact_valid (deact_valid),
        .deact_tid   (deact_tid),
        .pick_valid  (rr_valid),
        .pick_tid    (rr_tid)
      );

      cts_age_pick #(.NTHREADS(NTHREADS), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_age (
        .cand       (active & elig & head_ok),
        .seq        (head_seq),
        .pick_valid (age_valid),
        .pick_tid   (age_tid)
      );

      assign grant_valid = use_rr ? rr_valid : age_valid;
      assign grant_tid   = use_rr ? rr_tid   : age_tid;
    end
  endgenerate

endmodule

// File: rtl/cts_chk.sv
module cts_chk
  import cts_pkg::*;
#(
  parameter  int NTHREADS = 4,
  parameter  int SEQ_W    = 16,
  localparam int TID_W    = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [1:0]                  policy,
  input logic [STAT_W*NTHREADS-1:0]  thr_status,
  input logic [NTHREADS-1:0]         head_rdy,
  input logic [NTHREADS-1:0]         rob_empty,
  input logic [SEQ_W*NTHREADS-1:0]   head_seq,
  input logic [NTHREADS-1:0]         active,
  input logic                        deact_valid,
  input logic [TID_W-1:0]            deact_tid,
  input logic                        grant_ready,
  input logic                        grant_valid,
  input logic [TID_W-1:0]            grant_tid
);

  // R1
  grant_status_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> may_commit(thr_status[grant_tid*STAT_W +: STAT_W]));

  // R7
  idle_tid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> (grant_tid == '0));

  generate
    if (NTHREADS == 1) begin : g_one
      // R11
      single_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid == (active[0] && may_commit(thr_status[STAT_W-1:0])));
    end else begin : g_many
      logic [NTHREADS-1:0] gone_q;
      logic                older_seen;

      always_ff @(posedge clk) begin
        if (!rst_n) gone_q <= '0;
        else if (deact_valid) gone_q[deact_tid] <= 1'b1;
      end

      always_comb begin
        older_seen = 1'b0;
        for (int i = 0; i < NTHREADS; i++) begin
          if (active[i] && head_rdy[i] && !rob_empty[i] &&
              may_commit(thr_status[i*STAT_W +: STAT_W])) begin
            if (head_seq[i*SEQ_W +: SEQ_W] < head_seq[grant_tid*SEQ_W +: SEQ_W])
              older_seen = 1'b1;
            if ((head_seq[i*SEQ_W +: SEQ_W] == head_seq[grant_tid*SEQ_W +: SEQ_W]) &&
                (TID_W'(i) < grant_tid))
              older_seen = 1'b1;
          end
        end
      end

      // R2
      grant_head_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (head_rdy[grant_tid] && !rob_empty[grant_tid]));

      // R5
      oldest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && policy != POL_ROTATE) |-> (active[grant_tid] && !older_seen));

      // R8
      removed_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && policy == POL_ROTATE) |-> !gone_q[grant_tid]);
    end
  endgenerate

endmodule

bind commit_thread_sel cts_chk #(.NTHREADS(NTHREADS), .SEQ_W(SEQ_W)) u_chk (.*);

// File: tb/sim_commit_thread_sel.sv
module sim_commit_thread_sel;

  localparam [2:0] ID = 3'd0, RN = 3'd1, SQ = 3'd2, TP = 3'd3, FT = 3'd4, SA = 3'd5;

  typedef struct {
    logic       v;
    logic [1:0] t;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]  pol = 2'd0;
  logic [11:0] st  = '0;
  logic [3:0]  rdy = '0, emp = '0, act = '0;
  logic [63:0] seq = '0;
  logic        gr = 1'b0, dv = 1'b0;
  logic [1:0]  dt = '0;
  logic        gv;
  logic [1:0]  gt;

  logic [2:0]  st1 = '0;
  logic        rdy1 = 1'b0, emp1 = 1'b1, act1 = 1'b0;
  logic [15:0] seq1 = '0;
  logic        gv1;
  logic        gt1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t exp_q[$];
  event drv_ev;

  commit_thread_sel #(.NTHREADS(4), .SEQ_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .policy(pol), .thr_status(st), .head_rdy(rdy),
    .rob_empty(emp), .head_seq(seq), .active(act), .deact_valid(dv),
    .deact_tid(dt), .grant_ready(gr), .grant_valid(gv), .grant_tid(gt)
  );

  commit_thread_sel #(.NTHREADS(1), .SEQ_W(16)) u1 (
    .clk(clk), .rst_n(rst_n), .policy(2'd0), .thr_status(st1), .head_rdy(rdy1),
    .rob_empty(emp1), .head_seq(seq1), .active(act1), .deact_valid(1'b0),
    .deact_tid(1'b0), .grant_ready(1'b0), .grant_valid(gv1), .grant_tid(gt1)
  );

  function automatic logic [11:0] S(input [2:0] a, input [2:0] b, input [2:0] c, input [2:0] d);
    return {d, c, b, a};
  endfunction

  function automatic logic [63:0] Q(input [15:0] a, input [15:0] b, input [15:0] c, input [15:0] d);
    return {d, c, b, a};
  endfunction

  task automatic step(input [1:0] p, input [11:0] s, input [3:0] r, input [3:0] e,
                      input [3:0] a, input logic take, input logic dvi, input [1:0] dti,
                      input logic ev, input [1:0] et, input string tag);
    exp_t x;
    @(negedge clk);
    pol = p; st = s; rdy = r; emp = e; act = a; gr = take; dv = dvi; dt = dti;
    x.v = ev; x.t = et; x.tag = tag;
    exp_q.push_back(x);
    -> drv_ev;
  endtask

  // Monitor: pop one expectation per driven step, compare before the next edge.
  initial begin
    exp_t x;
    forever begin
      @(drv_ev);
      #1;
      x = exp_q.pop_front();
      checks++;
      if (gv !== x.v || (x.v && gt !== x.t) || (!x.v && gt !== 2'd0)) begin
        errors++;
        $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
                 x.tag, gv, gt, x.v, x.v ? x.t : 2'd0);
      end
    end
  end

  task automatic chk1(input logic ev, input string tag);
    #1;
    checks++;
    if (gv1 !== ev || gt1 !== 1'b0) begin
      errors++;
      $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=0", tag, gv1, gt1, ev);
    end
  endtask

  initial begin
    logic [11:0] ALL;
    ALL = S(RN, RN, RN, RN);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // Rotating policy: reset order and rotation
    step(0, ALL, 4'hF, 4'h0, 4'hF, 0, 0, 0, 1, 0, "R3 reset order front");
    step(0, ALL, 4'hF, 4'h0, 4'hF, 0, 0, 0, 1, 0, "R4 no rotation without ready");
    step(0, ALL, 4'hF, 4'h0, 4'hF, 1, 0, 0, 1, 0, "R4 rotate 1");
    step(0, ALL, 4'hF, 4'h0, 4'hF, 1, 0, 0, 1, 1, "R4 rotate 2");
    step(0, ALL, 4'hF, 4'h0, 4'hF, 1, 0, 0, 1, 2, "R4 rotate 3");
    step(0, ALL, 4'hF, 4'h0, 4'hF, 1, 0, 0, 1, 3, "R4 rotate 4");
    step(0, ALL, 4'hF, 4'h0, 4'hF, 1, 0, 0, 1, 0, "R4 rotate wrap");
    // order now 1,2,3,0
    step(0, ALL, 4'b0101, 4'h0, 4'hF, 1, 0, 0, 1, 2, "R3 first qualifying in order");
    // order now 1,3,0,2
    step(0, ALL, 4'b0101, 4'h0, 4'hF, 0, 0, 0, 1, 0, "R4 granted thread moved to back");
    step(0, S(SA, SQ, RN, TP), 4'hF, 4'h0, 4'hF, 0, 0, 0, 1, 2, "R1 blocked statuses skipped");
    step(0, S(FT, SQ, ID, TP), 4'hF, 4'h0, 4'hF, 0, 0, 0, 1, 0, "R1 fetch-trap-pending eligible");
    step(0, S(TP, SQ, ID, SA), 4'hF, 4'h0, 4'hF, 0, 0, 0, 1, 2, "R1 idle eligible");
    step(0, ALL, 4'b1101, 4'b1001, 4'hF, 0, 0, 0, 1, 2, "R2 not-ready and empty skipped");
    // Deactivation
    step(0, ALL, 4'hF, 4'h0, 4'hF, 0, 1, 1, 1, 1, "R8 grant before removal takes effect");
    step(0, ALL, 4'b0010, 4'h0, 4'hF, 0, 0, 0, 0, 0, "R8 removed thread not granted");
    // order now 3,0,2
    step(0, ALL, 4'hF, 4'h0, 4'hF, 1, 1, 0, 1, 3, "R8 removal with consumed grant");
    step(0, ALL, 4'hF, 4'h0, 4'hF, 0, 0, 0, 1, 3, "R8 removal wins over rotation");
    step(0, ALL, 4'b0100, 4'h0, 4'hF, 0, 1, 1, 1, 2, "R8 absent thread removal");
    step(0, ALL, 4'hF, 4'h0, 4'hF, 0, 0, 0, 1, 3, "R8 absent removal left order intact");
    step(0, ALL, 4'b0001, 4'h0, 4'hF, 0, 0, 0, 0, 0, "R8 second removed thread");
    step(0, ALL, 4'h0, 4'h0, 4'hF, 0, 0, 0, 0, 0, "R7 nothing qualifies");

    // Oldest-first policy
    @(negedge clk); seq = Q(16'd40, 16'd10, 16'd30, 16'd20);
    step(1, ALL, 4'hF, 4'h0, 4'hF, 1, 0, 0, 1, 1, "R5 smallest sequence");
    step(1, ALL, 4'hF, 4'h0, 4'b1101, 1, 0, 0, 1, 3, "R5 inactive skipped");
    step(1, S(RN, RN, RN, SQ), 4'hF, 4'h0, 4'b1101, 1, 0, 0, 1, 2, "R5 status gate");
    @(negedge clk); seq = Q(16'd5, 16'd9, 16'd5, 16'd7);
    step(1, ALL, 4'hF, 4'h0, 4'hF, 1, 0, 0, 1, 0, "R5 tie lowest index");
    step(1, ALL, 4'h0, 4'h0, 4'hF, 0, 0, 0, 0, 0, "R7 oldest none ready");
    @(negedge clk); seq = Q(16'd40, 16'd10, 16'd30, 16'd20);
    step(2, ALL, 4'hF, 4'h0, 4'hF, 1, 0, 0, 1, 1, "R6 greedy as oldest");
    step(3, ALL, 4'hF, 4'h0, 4'b1101, 1, 0, 0, 1, 3, "R6 code 3 as oldest");
    step(0, ALL, 4'hF, 4'h0, 4'hF, 0, 0, 0, 1, 3, "R9 order unchanged by oldest grants");
    step(0, ALL, 4'b0100, 4'h0, 4'hF, 0, 0, 0, 1, 2, "R10 same-cycle response");

    // Single-thread build
    @(negedge clk); st1 = RN; act1 = 1'b1; rdy1 = 1'b0; emp1 = 1'b1;
    chk1(1'b1, "R11 active eligible thread granted");
    @(negedge clk); st1 = TP;
    chk1(1'b0, "R11 trap status blocks");
    @(negedge clk); st1 = FT; act1 = 1'b0;
    chk1(1'b0, "R11 inactive blocks");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got hang, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule